// File: doc/BRIEF.md
# Read-Only NAND Flash Target Model

This block is a synthesizable stand-in for a small NAND flash device that can only be read. It sits on a raw parallel NAND bus as the target. The bus has an 8-bit shared command, address and data lane, one active-low enable per chip, active-low read and write strobes, and two latch-enable lines that mark a write-strobe byte as either a command or an address. Two chips share the bus, and each keeps its own read mode, address-cycle count and byte pointer.

A host issues a read-mode command and then three address cycles. The first cycle gives the column, which the mode offsets within a 528-byte page. The second and third cycles give row numbers that are scaled by the page size. They are not concatenated. Each read strobe then returns the byte under the pointer and moves the pointer on by one. Illegal commands, surplus address cycles and data writes are reported on an error pulse and change nothing.

The content is computed rather than stored. Inside the array, a byte is the XOR of the pointer's 8-bit slices, salted per chip. Every pointer at or beyond the array size reads as erased. The array size is a parameter. Bus lines are synchronised into the block clock, and each action fires on the falling edge of its strobe.

Top module: `nand_rd_model`

## Requirements
- R1: After reset, `dout_oe` is 0, `rdy` is 0 for both chips, `err` is 0, and both chips are idle with their pointers at 0.
- R2: Command 0xFF returns the selected chip to idle. Commands 0x00, 0x01 and 0x50 select read mode A, B and C and clear the address-cycle counter, so a chip that has already taken three cycles accepts three new ones without error.
- R3: Any other command byte raises `err` for one clock. The chip's mode and address-cycle counter stay as they were.
- R4: A write-strobe fall with `cle` high is a command even when `ale` is also high. With `cle` low and `ale` high, the byte is an address.
- R5: The first address cycle sets the pointer to the byte. Read mode B also sets pointer bit 8 (adds 0x100), and read mode C also sets pointer bit 9 (adds 0x200).
- R6: The second address cycle adds byte × 135168 (528 × 256) to the pointer. The third adds byte × 528.
- R7: A fourth address cycle, or an address cycle while idle, raises `err` for one clock and leaves the pointer unchanged.
- R8: A read-strobe fall with both latch enables low puts content(pointer) on `dout` and then increments the pointer. This happens in any mode. For pointer p below ARRAY_BYTES, content is p[7:0] ^ p[15:8] ^ p[23:16] ^ p[25:24], XORed with 0x00 for chip 0 and 0x5A for chip 1. For p of ARRAY_BYTES or more, content is 0xFF.
- R9: Chip 0 is selected when `ce_n[0]` is 0. Chip 1 is selected only when `ce_n[1]` is 0 and `ce_n[0]` is 1. Strobes affect only the selected chip.
- R10: `rdy[k]` goes to 1 once chip k is selected while both strobes are high, and stays at 1 after that.
- R11: `dout_oe` rises only as a result of a read of a selected chip. It falls when the read strobe returns high or no chip is selected.
- R12: A write-strobe fall to a selected chip with both latch enables low (a data write) raises `err` for one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | NUM_CHIPS | Active-low chip enables; bit 0 has priority |
| re_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| din | input | 8 | Bus byte seen by the target |
| dout | output | 8 | Read byte to drive onto the bus |
| dout_oe | output | 1 | Tri-state enable for `dout` |
| rdy | output | NUM_CHIPS | Ready, one per chip |
| err | output | 1 | One-clock pulse on an illegal bus action |

## Verification
Every bus line passes through two synchroniser flops, and an edge register follows them. A pin change therefore reaches the registered outputs at the third rising clock edge after it. The bench sets the enable, latch and data lines three cycles before a strobe falls. It holds each strobe level for six cycles and samples `dout`, `dout_oe` and `rdy` on a falling clock edge after that window. `err` lasts only one clock, so the bench counts its pulses on every rising edge and compares the count before and after each bus action.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_RD_A = 2'd1,
    MD_RD_B = 2'd2,
    MD_RD_C = 2'd3
  } rd_mode_e;

  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_RD_A  = 8'h00;
  localparam logic [7:0] CMD_RD_B  = 8'h01;
  localparam logic [7:0] CMD_RD_C  = 8'h50;
endpackage

// File: rtl/nand_rd_sync.sv
module nand_rd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/nand_rd_store.sv
module nand_rd_store #(
  parameter int PTR_W = 26,
  parameter int unsigned ARRAY_BYTES = 32'd16777216,
  parameter logic [7:0] SALT = 8'h00
) (
  input  logic [PTR_W-1:0] ptr,
  output logic [7:0]       rd_byte
);
  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(ARRAY_BYTES);

  logic [7:0] fold;

  always_comb begin
    fold = SALT;
    for (int i = 0; i < PTR_W; i++) fold[i % 8] = fold[i % 8] ^ ptr[i];
  end

  assign rd_byte = ({1'b0, ptr} < LIMIT) ? fold : 8'hFF;
endmodule

// File: rtl/nand_rd_chip.sv
module nand_rd_chip
  import nand_rd_pkg::*;
#(
  parameter int PTR_W = 26,
  parameter int PAGE_BYTES = 528
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             cmd_stb,
  input  logic             adr_stb,
  input  logic             rd_stb,
  input  logic [7:0]       din,
  output logic [PTR_W-1:0] ptr_q,
  output rd_mode_e         mode_q,
  output logic             bad
);
  localparam logic [PTR_W-1:0] PAGE_STEP = PTR_W'(PAGE_BYTES);
  localparam logic [PTR_W-1:0] BANK_STEP = PTR_W'(PAGE_BYTES * 256);

  rd_mode_e         mode_d;
  logic [PTR_W-1:0] ptr_d;
  logic [1:0]       cyc_q, cyc_d;
  logic             upd;
  logic [PTR_W-1:0] byte_w;

  assign byte_w = PTR_W'(din);
  assign upd    = sel & (cmd_stb | adr_stb | rd_stb);

  always_comb begin
    mode_d = mode_q;
    ptr_d  = ptr_q;
    cyc_d  = cyc_q;
    bad    = 1'b0;
    if (sel && cmd_stb) begin
      unique case (din)
        CMD_RESET: mode_d = MD_IDLE;
        CMD_RD_A: begin mode_d = MD_RD_A; cyc_d = 2'd0; end
        CMD_RD_B: begin mode_d = MD_RD_B; cyc_d = 2'd0; end
        CMD_RD_C: begin mode_d = MD_RD_C; cyc_d = 2'd0; end
        default:  bad = 1'b1;
      endcase
    end else if (sel && adr_stb) begin
      if (mode_q == MD_IDLE || cyc_q == 2'd3) begin
        bad = 1'b1;
      end else begin
        cyc_d = cyc_q + 2'd1;
        unique case (cyc_q)
          2'd0: begin
            ptr_d = byte_w;
            if (mode_q == MD_RD_B) ptr_d[8] = 1'b1;
            if (mode_q == MD_RD_C) ptr_d[9] = 1'b1;
          end
          2'd1:    ptr_d = ptr_q + byte_w * BANK_STEP;
          default: ptr_d = ptr_q + byte_w * PAGE_STEP;
        endcase
      end
    end else if (sel && rd_stb) begin
      ptr_d = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_IDLE;
      ptr_q  <= '0;
      cyc_q  <= 2'd0;
    end else if (upd) begin
      mode_q <= mode_d;
      ptr_q  <= ptr_d;
      cyc_q  <= cyc_d;
    end
  end
endmodule

// File: rtl/nand_rd_model.sv
module nand_rd_model
  import nand_rd_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int PTR_W = 26,
  parameter int PAGE_BYTES = 528,
  parameter int unsigned ARRAY_BYTES = 32'd16777216,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CHIPS-1:0] ce_n,
  input  logic                 re_n,
  input  logic                 we_n,
  input  logic                 cle,
  input  logic                 ale,
  input  logic [7:0]           din,
  output logic [7:0]           dout,
  output logic                 dout_oe,
  output logic [NUM_CHIPS-1:0] rdy,
  output logic                 err
);
  localparam int SW = 12 + NUM_CHIPS;
  localparam logic [SW-1:0] SYNC_RST = {8'h00, 1'b0, 1'b0, {NUM_CHIPS{1'b1}}, 1'b1, 1'b1};

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [SW-1:0]        sync_q;
  logic [7:0]           din_s;
  logic                 ale_s, cle_s, we_s, re_s;
  logic [NUM_CHIPS-1:0] ce_s;

  nand_rd_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d    ({din, ale, cle, ce_n, we_n, re_n}),
    .q    (sync_q)
  );
  assign {din_s, ale_s, cle_s, ce_s, we_s, re_s} = sync_q;

  logic we_p, re_p;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      we_p <= 1'b1;
      re_p <= 1'b1;
    end else begin
      we_p <= we_s;
      re_p <= re_s;
    end
  end

  logic we_fall, re_fall, cmd_stb, adr_stb, rd_stb, wr_bad, any_sel;
  logic [NUM_CHIPS-1:0] sel;

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int k = 0; k < NUM_CHIPS; k++) begin
      sel[k] = ~ce_s[k] & ~taken;
      taken  = taken | ~ce_s[k];
    end
  end

  assign any_sel = |sel;
  assign we_fall = we_p & ~we_s;
  assign re_fall = re_p & ~re_s;
  assign cmd_stb = we_fall & cle_s;
  assign adr_stb = we_fall & ~cle_s & ale_s;
  assign rd_stb  = re_fall & ~cle_s & ~ale_s;
  assign wr_bad  = we_fall & ~cle_s & ~ale_s & any_sel;

  logic [PTR_W-1:0]     ptr_q   [NUM_CHIPS];
  rd_mode_e             mode_q  [NUM_CHIPS];
  logic [7:0]           rd_byte [NUM_CHIPS];
  logic [NUM_CHIPS-1:0] bad;

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_chip
    nand_rd_chip #(.PTR_W(PTR_W), .PAGE_BYTES(PAGE_BYTES)) i_chip (
      .clk    (clk),
      .rst_n  (rst_sn),
      .sel    (sel[k]),
      .cmd_stb(cmd_stb),
      .adr_stb(adr_stb),
      .rd_stb (rd_stb),
      .din    (din_s),
      .ptr_q  (ptr_q[k]),
      .mode_q (mode_q[k]),
      .bad    (bad[k])
    );
    nand_rd_store #(.PTR_W(PTR_W), .ARRAY_BYTES(ARRAY_BYTES), .SALT(8'(k * 90))) i_store (
      .ptr    (ptr_q[k]),
      .rd_byte(rd_byte[k])
    );
  end

  logic [7:0] rd_sel;
  always_comb begin
    rd_sel = 8'h00;
    for (int k = 0; k < NUM_CHIPS; k++) if (sel[k]) rd_sel = rd_byte[k];
  end

  logic                 oe_set, oe_d, err_d;
  logic [NUM_CHIPS-1:0] rdy_d;

  assign oe_set = rd_stb & any_sel;
  assign err_d  = wr_bad | (|bad);

  always_comb begin
    oe_d = dout_oe;
    if (oe_set)                 oe_d = 1'b1;
    else if (re_s || !any_sel)  oe_d = 1'b0;
    rdy_d = rdy | (sel & {NUM_CHIPS{re_s & we_s}});
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dout_oe <= 1'b0;
      rdy     <= '0;
      err     <= 1'b0;
    end else begin
      dout_oe <= oe_d;
      rdy     <= rdy_d;
      err     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     dout <= 8'h00;
    else if (oe_set) dout <= rd_sel;
  end
endmodule

// File: rtl/nand_rd_chk.sv
module nand_rd_chk
  import nand_rd_pkg::*;
#(
  parameter int PTR_W = 26,
  parameter int NUM_CHIPS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dout_oe,
  input logic [NUM_CHIPS-1:0] rdy,
  input logic                 err,
  input logic                 re_s,
  input logic                 sel0,
  input logic                 rd_stb,
  input logic [PTR_W-1:0]     ptr0,
  input logic [PTR_W-1:0]     ptr1,
  input rd_mode_e             mode0,
  input rd_mode_e             mode1
);
  // R11
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_s) |=> !dout_oe);

  // R11
  oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(rd_stb));

  // R10
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy & $past(rdy)) == $past(rdy));

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && sel0) |=> ptr0 == $past(ptr0) + PTR_W'(1));

  // R9
  chip1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel0 |=> $stable(ptr1));

  // R3
  err_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(mode0) && $stable(mode1)));
endmodule

bind nand_rd_model nand_rd_chk #(.PTR_W(PTR_W), .NUM_CHIPS(NUM_CHIPS)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dout_oe(dout_oe),
  .rdy    (rdy),
  .err    (err),
  .re_s   (re_s),
  .sel0   (sel[0]),
  .rd_stb (rd_stb),
  .ptr0   (ptr_q[0]),
  .ptr1   (ptr_q[1]),
  .mode0  (mode_q[0]),
  .mode1  (mode_q[1])
);

// File: tb/test_nand_rd_model.sv
module test_nand_rd_model;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ce_n = 2'b11;
  logic       re_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_oe, err;
  logic [1:0] rdy;

  int total = 0, fails = 0, err_cnt = 0;
  int p0 = 0, p1 = 0;

  always #2.5 clk = ~clk;

  nand_rd_model i_nand_rd_model (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
    .cle(cle), .ale(ale), .din(din), .dout(dout), .dout_oe(dout_oe),
    .rdy(rdy), .err(err)
  );

  always @(posedge clk) if (rst_n && err === 1'b1) err_cnt <= err_cnt + 1;

  localparam logic [1:0] C0 = 2'b10, C1 = 2'b01, CBOTH = 2'b00;

  function automatic int content(input int chip, input int p);
    int v;
    if (p >= 16777216) return 8'hFF;
    v = (p & 255) ^ ((p >> 8) & 255) ^ ((p >> 16) & 255) ^ ((p >> 24) & 3);
    return chip ? (v ^ 8'h5A) : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ce, input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    ce_n = ce; cle = c; ale = a; din = b;
    repeat (3) @(negedge clk);
    we_n = 1'b0;
    repeat (6) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] ce, input logic [7:0] b);
    wr(ce, 1'b1, 1'b0, b);
  endtask

  task automatic adr(input logic [1:0] ce, input logic [7:0] b);
    wr(ce, 1'b0, 1'b1, b);
  endtask

  task automatic rd(input logic [1:0] ce, output int b, output int oe_on);
    @(negedge clk);
    ce_n = ce; cle = 1'b0; ale = 1'b0;
    repeat (3) @(negedge clk);
    re_n = 1'b0;
    repeat (6) @(negedge clk);
    b = dout; oe_on = dout_oe;
    re_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd_chk0(input string tag);
    int b, oe;
    rd(C0, b, oe);
    chk(tag, b, content(0, p0));
    p0++;
  endtask

  task automatic t_reset();
    chk("R1 dout_oe", dout_oe, 0);
    chk("R1 rdy", rdy, 0);
    chk("R1 err", err_cnt, 0);
  endtask

  task automatic t_ready();
    @(negedge clk); ce_n = C0;
    repeat (6) @(negedge clk);
    chk("R10 rdy chip0 only", rdy, 2'b01);
  endtask

  task automatic t_mode_a();
    int b, oe;
    cmd(C0, 8'h00); adr(C0, 8'h12); adr(C0, 8'h01); adr(C0, 8'h02);
    p0 = 'h12 + 135168 + 2 * 528;
    rd(C0, b, oe);
    chk("R6 R8 mode A first byte", b, content(0, p0));
    chk("R11 oe during read", oe, 1);
    p0++;
    rd_chk0("R8 increment 1");
    rd_chk0("R8 increment 2");
  endtask

  task automatic t_mode_bc();
    cmd(C0, 8'h01); adr(C0, 8'h34); adr(C0, 8'h00); adr(C0, 8'h00);
    p0 = 'h134;
    rd_chk0("R5 mode B column");
    cmd(C0, 8'h50); adr(C0, 8'h05); adr(C0, 8'h00); adr(C0, 8'h03);
    p0 = 'h205 + 3 * 528;
    rd_chk0("R5 R6 mode C column and page");
  endtask

  task automatic t_prio();
    int e;
    cmd(C0, 8'hFF);
    e = err_cnt;
    wr(C0, 1'b1, 1'b1, 8'h00);
    adr(C0, 8'h07); adr(C0, 8'h00); adr(C0, 8'h00);
    chk("R4 cle over ale no err", err_cnt - e, 0);
    p0 = 7;
    rd_chk0("R4 command taken");
  endtask

  task automatic t_extra();
    int e;
    e = err_cnt;
    adr(C0, 8'h55);
    chk("R7 fourth cycle err", err_cnt - e, 1);
    rd_chk0("R7 pointer kept");
    cmd(C0, 8'hFF);
    e = err_cnt;
    adr(C0, 8'h10);
    chk("R7 idle address err", err_cnt - e, 1);
    rd_chk0("R7 idle pointer kept");
  endtask

  task automatic t_illegal();
    int e;
    cmd(C0, 8'h00); adr(C0, 8'h20);
    e = err_cnt;
    cmd(C0, 8'h90);
    chk("R3 illegal err", err_cnt - e, 1);
    adr(C0, 8'h00); adr(C0, 8'h00);
    chk("R3 mode and counter kept", err_cnt - e, 1);
    adr(C0, 8'h00);
    chk("R3 counter reached three", err_cnt - e, 2);
    p0 = 'h20;
    rd_chk0("R3 pointer after illegal");
    e = err_cnt;
    cmd(C0, 8'h01); adr(C0, 8'h10); adr(C0, 8'h00); adr(C0, 8'h00);
    chk("R2 counter cleared", err_cnt - e, 0);
    p0 = 'h110;
    rd_chk0("R2 reentered mode B");
  endtask

  task automatic t_chips();
    int b, oe;
    cmd(C1, 8'h00); adr(C1, 8'h40); adr(C1, 8'h00); adr(C1, 8'h00);
    p1 = 'h40;
    rd(C1, b, oe);
    chk("R9 chip1 byte", b, content(1, p1));
    p1++;
    rd_chk0("R9 chip0 untouched");
    rd(CBOTH, b, oe);
    chk("R9 both low picks chip0", b, content(0, p0));
    p0++;
    rd(C1, b, oe);
    chk("R9 chip1 own pointer", b, content(1, p1));
    p1++;
    chk("R10 rdy both", rdy, 2'b11);
  endtask

  task automatic t_bounds();
    cmd(C0, 8'h00); adr(C0, 8'h0E); adr(C0, 8'd124); adr(C0, 8'd31);
    p0 = 'h0E + 124 * 135168 + 31 * 528;
    rd_chk0("R8 last bytes of array");
    rd_chk0("R8 last byte of array");
    rd_chk0("R8 first byte past array");
    cmd(C0, 8'h00); adr(C0, 8'h00); adr(C0, 8'd200); adr(C0, 8'h00);
    p0 = 200 * 135168;
    rd_chk0("R8 far out of range");
  endtask

  task automatic t_bus();
    int e;
    @(negedge clk); ce_n = C0;
    repeat (6) @(negedge clk);
    chk("R11 oe idle", dout_oe, 0);
    rd_chk0("R11 read");
    chk("R11 oe released", dout_oe, 0);
    e = err_cnt;
    wr(C0, 1'b0, 1'b0, 8'hAA);
    chk("R12 data write err", err_cnt - e, 1);
    rd_chk0("R12 pointer kept");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_ready();
    t_mode_a();
    t_mode_bc();
    t_prio();
    t_extra();
    t_illegal();
    t_chips();
    t_bounds();
    t_bus();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule